// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces the status side of a parallel NOR flash device. It follows the command decoder. It knows whether an embedded program or erase is running, whether an erase has been suspended, and whether a program is running inside that suspension. It drives a ready/busy line and a polling status byte from that knowledge. While an operation is running, every new read cycle inverts bit 6 of the byte returned, so software can poll for completion. When nothing is running, reads return the array data that the array side presents to the block.

Commands aimed at protected sectors start no real operation. The block instead shows a short busy window with toggling, then returns to its previous mode by itself. A protected program gives a short window. A fully protected erase gives a long window. Both lengths are clock-cycle counts set by parameters. All inputs are single-cycle, synchronous strobes from neighbouring logic. The command strobes mark the final write pulse of a command sequence, so status is valid on the cycle after each strobe. There is no streaming data path, so the block has no valid/ready handshake.

Top module: `flash_status_gen`

## Requirements
- R1: After reset the ready/busy enable is low (line released), the mode is array-read, and `status_q` equals `array_data`.
- R2: In array-read, `cmd_prog` with `target_prot` low drives `rb_drive_low` high from the next cycle. It stays high until an `op_done` pulse, after which the line is released and `status_q` returns `array_data`.
- R3: In array-read, `cmd_erase` with `target_prot` low starts an erase with the same busy behaviour. If `cmd_erase` and `cmd_prog` arrive in the same cycle, the erase wins.
- R4: While busy, `status_q` is 0x00 except bit 6. Bit 6 is 0 on entry from any non-busy mode. It inverts once per rising edge of `rd_strobe`, and does not change otherwise.
- R5: `cmd_suspend` during an erase releases the line on the next cycle. Reads then return `array_data` without toggling. `cmd_resume` makes the block busy with the erase again.
- R6: `cmd_prog` (unprotected) while erase-suspended makes the block busy and toggling. Its `op_done` returns the block to erase-suspend, not to array-read.
- R7: `cmd_prog` with `target_prot` high, given in array-read, holds busy and toggling for exactly SHORT_CYC cycles. The block then returns to array-read.
- R8: `cmd_erase` with `target_prot` high, given in array-read, holds busy and toggling for exactly LONG_CYC cycles. The block then returns to array-read.
- R9: A protected `cmd_prog` while erase-suspended gives a SHORT_CYC window and then returns to erase-suspend.
- R10: These strobes have no effect: `cmd_suspend`, `cmd_resume` and `op_done` in array-read; `cmd_prog`, `cmd_erase` and `cmd_suspend` during a program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_prog | input | 1 | Program command accepted (one-cycle strobe) |
| cmd_erase | input | 1 | Erase command accepted (one-cycle strobe) |
| cmd_suspend | input | 1 | Erase-suspend command accepted |
| cmd_resume | input | 1 | Erase-resume command accepted |
| target_prot | input | 1 | Target of the program/erase command is protected |
| op_done | input | 1 | Embedded operation finished (one-cycle pulse) |
| rd_strobe | input | 1 | Read cycle active (output-enable or chip-enable framed) |
| array_data | input | DATA_W | Array byte returned when not busy |
| rb_drive_low | output | 1 | Open-drain enable: 1 pulls ready/busy low |
| status_q | output | DATA_W | Byte returned on reads |

## Verification
The bench targets these corner cases:
- A program strobe and an erase strobe in the same cycle. A design that favoured the program would ignore the later suspend and stay busy.
- A program finishing inside an erase suspension. A design that fell back to array-read would then ignore the resume.
- The length of each protected-target window, counted to the exact cycle, for a short window that must return to the suspended state and not to array-read.
- Idle periods with no read edges while busy. Here a free-running or level-sensitive toggle would change bit 6.
- Strobes that arrive in the wrong mode. A design that reacted to them would change the line level or the returned byte.

// File: rtl/flash_status_pkg.sv
`timescale 1ns/1ps
package flash_status_pkg;

  typedef enum logic [2:0] {
    M_IDLE   = 3'd0,  // array read / standby
    M_PROG   = 3'd1,  // embedded program
    M_ERASE  = 3'd2,  // embedded erase
    M_ESUSP  = 3'd3,  // erase suspended, array readable
    M_ESPROG = 3'd4,  // program inside erase suspension
    M_PWIN   = 3'd5   // protected-target toggle window
  } op_mode_e;

  function automatic logic mode_busy(input op_mode_e m);
    return (m == M_PROG) || (m == M_ERASE) || (m == M_ESPROG) || (m == M_PWIN);
  endfunction

endpackage

// File: rtl/fsg_window_timer.sv
`timescale 1ns/1ps
module fsg_window_timer #(
  parameter int unsigned LONG_CYC  = 25000,
  parameter int unsigned SHORT_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_long,
  input  logic load_short,
  input  logic win_active,
  output logic win_expire
);
  localparam int unsigned MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'((LONG_CYC  > 0) ? LONG_CYC  - 1 : 0);
  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'((SHORT_CYC > 0) ? SHORT_CYC - 1 : 0);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load_long) begin
      remain <= LONG_LD;
    end else if (load_short) begin
      remain <= SHORT_LD;
    end else if (win_active && (remain != '0)) begin
      remain <= remain - 1'b1;
    end
  end

  assign win_expire = win_active && (remain == '0);

endmodule

// File: rtl/fsg_mode_fsm.sv
`timescale 1ns/1ps
module fsg_mode_fsm
  import flash_status_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_prog,
  input  logic     cmd_erase,
  input  logic     cmd_suspend,
  input  logic     cmd_resume,
  input  logic     target_prot,
  input  logic     op_done,
  input  logic     win_expire,
  output op_mode_e mode,
  output logic     load_long,
  output logic     load_short
);
  op_mode_e mode_nxt;
  logic     back_to_susp, back_to_susp_nxt;

  always_comb begin
    mode_nxt         = mode;
    back_to_susp_nxt = back_to_susp;
    load_long        = 1'b0;
    load_short       = 1'b0;
    unique case (mode)
      M_IDLE: begin
        if (cmd_erase) begin
          if (target_prot) begin
            mode_nxt         = M_PWIN;
            load_long        = 1'b1;
            back_to_susp_nxt = 1'b0;
          end else begin
            mode_nxt = M_ERASE;
          end
        end else if (cmd_prog) begin
          if (target_prot) begin
            mode_nxt         = M_PWIN;
            load_short       = 1'b1;
            back_to_susp_nxt = 1'b0;
          end else begin
            mode_nxt = M_PROG;
          end
        end
      end
      M_PROG: begin
        if (op_done) mode_nxt = M_IDLE;
      end
      M_ERASE: begin
        if (op_done)          mode_nxt = M_IDLE;
        else if (cmd_suspend) mode_nxt = M_ESUSP;
      end
      M_ESUSP: begin
        if (cmd_resume) begin
          mode_nxt = M_ERASE;
        end else if (cmd_prog) begin
          if (target_prot) begin
            mode_nxt         = M_PWIN;
            load_short       = 1'b1;
            back_to_susp_nxt = 1'b1;
          end else begin
            mode_nxt = M_ESPROG;
          end
        end
      end
      M_ESPROG: begin
        if (op_done) mode_nxt = M_ESUSP;
      end
      M_PWIN: begin
        if (win_expire) mode_nxt = back_to_susp ? M_ESUSP : M_IDLE;
      end
      default: mode_nxt = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode         <= M_IDLE;
      back_to_susp <= 1'b0;
    end else begin
      mode         <= mode_nxt;
      back_to_susp <= back_to_susp_nxt;
    end
  end

endmodule

// File: rtl/fsg_toggle.sv
`timescale 1ns/1ps
module fsg_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_strobe,
  input  logic busy,
  output logic rd_rise,
  output logic tog
);
  logic rd_prev;

  assign rd_rise = rd_strobe && !rd_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev <= 1'b0;
      tog     <= 1'b0;
    end else begin
      rd_prev <= rd_strobe;
      if (!busy)        tog <= 1'b0;
      else if (rd_rise) tog <= ~tog;
    end
  end

endmodule

// File: rtl/flash_status_gen.sv
`timescale 1ns/1ps
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned TOG_BIT   = 6,
  parameter int unsigned LONG_CYC  = 25000,
  parameter int unsigned SHORT_CYC = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_prog,
  input  logic              cmd_erase,
  input  logic              cmd_suspend,
  input  logic              cmd_resume,
  input  logic              target_prot,
  input  logic              op_done,
  input  logic              rd_strobe,
  input  logic [DATA_W-1:0] array_data,
  output logic              rb_drive_low,
  output logic [DATA_W-1:0] status_q
);
  op_mode_e mode;
  logic     load_long, load_short, win_expire;
  logic     busy, tog, rd_rise;

  fsg_mode_fsm u_fsm (
    .clk, .rst_n, .cmd_prog, .cmd_erase, .cmd_suspend, .cmd_resume,
    .target_prot, .op_done, .win_expire,
    .mode, .load_long, .load_short
  );

  fsg_window_timer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_timer (
    .clk, .rst_n, .load_long, .load_short,
    .win_active(mode == M_PWIN),
    .win_expire
  );

  assign busy = mode_busy(mode);

  fsg_toggle u_tog (
    .clk, .rst_n, .rd_strobe, .busy, .rd_rise, .tog
  );

  assign rb_drive_low = busy;

  for (genvar b = 0; b < DATA_W; b++) begin : g_stat
    if (b == TOG_BIT) begin : g_tog
      assign status_q[b] = busy ? tog : array_data[b];
    end else begin : g_other
      assign status_q[b] = busy ? 1'b0 : array_data[b];
    end
  end

endmodule

// File: rtl/flash_status_gen_chk.sv
`timescale 1ns/1ps
module flash_status_gen_chk
  import flash_status_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned TOG_BIT = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_prog,
  input logic              cmd_erase,
  input logic              cmd_suspend,
  input logic              target_prot,
  input logic              op_done,
  input logic [DATA_W-1:0] array_data,
  input logic              rb_drive_low,
  input logic [DATA_W-1:0] status_q,
  input op_mode_e          mode,
  input logic              rd_rise,
  input logic              win_expire
);
  // R2
  prog_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_IDLE && cmd_prog && !cmd_erase && !target_prot) |=> rb_drive_low);

  // R5
  suspend_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ERASE && cmd_suspend && !op_done) |=> (!rb_drive_low && status_q == array_data));

  // R4
  toggle_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_drive_low && rd_rise) |=> (!rb_drive_low || status_q[TOG_BIT] != $past(status_q[TOG_BIT])));

  // R4
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_drive_low && !rd_rise) |=> (!rb_drive_low || $stable(status_q[TOG_BIT])));

  // R7
  window_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_expire |=> (mode != M_PWIN));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_IDLE && !cmd_prog && !cmd_erase) |=> (mode == M_IDLE && !rb_drive_low));

endmodule

bind flash_status_gen flash_status_gen_chk #(.DATA_W(DATA_W), .TOG_BIT(TOG_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_prog(cmd_prog), .cmd_erase(cmd_erase),
  .cmd_suspend(cmd_suspend), .target_prot(target_prot), .op_done(op_done),
  .array_data(array_data), .rb_drive_low(rb_drive_low), .status_q(status_q),
  .mode(mode), .rd_rise(rd_rise), .win_expire(win_expire)
);

// File: tb/flash_status_gen_tb.sv
`timescale 1ns/1ps
module flash_status_gen_tb;
  localparam int unsigned SHORT = 8;
  localparam int unsigned LONG  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_prog = 0, cmd_erase = 0, cmd_suspend = 0, cmd_resume = 0;
  logic target_prot = 0, op_done = 0, rd_strobe = 0;
  logic [7:0] array_data = 8'hA5;
  logic rb_drive_low;
  logic [7:0] status_q;
  logic rb_pin;
  int checks = 0, failures = 0, cyc = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;  // 4 ns period
  always @(posedge clk) cyc++;

  // line with pull-up: low only when the block pulls it
  assign rb_pin = rb_drive_low ? 1'b0 : 1'b1;

  flash_status_gen #(.LONG_CYC(LONG), .SHORT_CYC(SHORT)) u_dut (
    .clk, .rst_n, .cmd_prog, .cmd_erase, .cmd_suspend, .cmd_resume,
    .target_prot, .op_done, .rd_strobe, .array_data, .rb_drive_low, .status_q
  );

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // which: 0 prog, 1 erase, 2 suspend, 3 resume, 4 done, 5 prog+erase
  task automatic pulse(input int which, input logic prot);
    @(negedge clk);
    target_prot = prot;
    case (which)
      0: cmd_prog = 1;
      1: cmd_erase = 1;
      2: cmd_suspend = 1;
      3: cmd_resume = 1;
      4: op_done = 1;
      default: begin cmd_prog = 1; cmd_erase = 1; end
    endcase
    @(negedge clk);
    {cmd_prog, cmd_erase, cmd_suspend, cmd_resume, op_done, target_prot} = '0;
  endtask

  task automatic do_read();
    @(negedge clk) rd_strobe = 1;
    @(negedge clk) rd_strobe = 0;
  endtask

  task automatic t_reset();
    chk(rb_pin, 1, "R1 line released");
    chk(status_q, array_data, "R1 array data");
  endtask

  task automatic t_program();
    pulse(0, 0);
    chk(rb_pin, 0, "R2 busy after program");
    chk(status_q, 8'h00, "R4 bit6 starts 0");
    do_read(); chk(status_q, 8'h40, "R4 first read");
    do_read(); chk(status_q, 8'h00, "R4 second read");
    do_read(); chk(status_q, 8'h40, "R4 third read");
    repeat (3) @(negedge clk);
    chk(status_q, 8'h40, "R4 no read no toggle");
    pulse(4, 0);
    chk(rb_pin, 1, "R2 released on done");
    chk(status_q, array_data, "R2 array data after done");
  endtask

  task automatic t_erase_priority();
    pulse(5, 0);
    chk(rb_pin, 0, "R3 busy after erase");
    pulse(2, 0);
    chk(rb_pin, 1, "R3 erase won, suspend accepted");
    pulse(3, 0);
    chk(rb_pin, 0, "R3 resumed busy");
    pulse(4, 0);
    chk(rb_pin, 1, "R3 released");
  endtask

  task automatic t_suspend_resume();
    pulse(1, 0);
    do_read();
    chk(status_q, 8'h40, "R4 erase toggles");
    pulse(2, 0);
    chk(rb_pin, 1, "R5 ready in suspend");
    array_data = 8'h3C;
    do_read(); do_read();
    chk(status_q, 8'h3C, "R5 suspend reads array");
    pulse(3, 0);
    chk(rb_pin, 0, "R5 resume busy");
    chk(status_q, 8'h00, "R4 bit6 restarts 0 after resume");
    pulse(4, 0);
    chk(rb_pin, 1, "R5 erase done");
  endtask

  task automatic t_susp_program();
    pulse(1, 0); pulse(2, 0);
    pulse(0, 0);
    chk(rb_pin, 0, "R6 busy in suspend program");
    do_read(); chk(status_q, 8'h40, "R6 toggles");
    pulse(4, 0);
    chk(rb_pin, 1, "R6 ready after program");
    pulse(3, 0);
    chk(rb_pin, 0, "R6 back in suspend, resume works");
    pulse(4, 0);
    chk(rb_pin, 1, "R6 final done");
  endtask

  task automatic window(input int which, input int len, input string req);
    int c0;
    pulse(which, 1);
    c0 = cyc;
    chk(rb_pin, 0, req);
    do_read(); chk(status_q, 8'h40, req);
    while (rb_pin === 1'b0 && (cyc - c0) < 1000) @(negedge clk);
    chk(cyc - c0, len, req);
    chk(status_q, array_data, req);
  endtask

  task automatic t_prot_susp_program();
    pulse(1, 0); pulse(2, 0);
    window(0, SHORT, "R9 window in suspend");
    pulse(3, 0);
    chk(rb_pin, 0, "R9 returned to suspend");
    pulse(4, 0);
    chk(rb_pin, 1, "R9 done");
  endtask

  task automatic t_ignored();
    pulse(2, 0); pulse(3, 0); pulse(4, 0);
    chk(rb_pin, 1, "R10 idle strobes ignored");
    chk(status_q, array_data, "R10 idle data");
    pulse(0, 0);
    pulse(1, 0); pulse(0, 0); pulse(2, 0);
    chk(rb_pin, 0, "R10 program unaffected");
    pulse(4, 0);
    chk(rb_pin, 1, "R10 one done ends program");
    pulse(3, 0);
    chk(rb_pin, 1, "R10 resume after program ignored");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_program();
    t_erase_priority();
    t_suspend_resume();
    t_susp_program();
    window(0, SHORT, "R7 protected program window");
    window(1, LONG, "R8 protected erase window");
    t_prot_susp_program();
    t_ignored();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done_flag) begin
      done_flag = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule